// File: doc/BRIEF.md
# Memory Bus Self-Test Engine

This engine exercises an attached byte-wide memory at power-up and reports whether its data and address wiring is sound. It drives a plain single-access port: a request strobe, a write enable, a byte address and write byte, plus a read byte qualified by a response strobe. A write completes in the cycle its request is high. A read is answered by one response strobe some cycles later. The engine never issues a new access while a read is waiting for its response.

A run is started by a start pulse and has three phases in a fixed order. The data-line phase writes a walking one to address 0 and reads it back. The address-line phase places 0xAA at address 0 and at every power-of-two offset inside the region. It then uses 0x55 to look for lines that are stuck low, stuck high or shorted. The optional sweep phase fills the whole region with 0xAA and verifies it, then does the same with 0x55. The level of the full-select input at start decides whether the sweep runs.

The first mismatch ends the run. The engine captures the phase, the address, the expected byte and the read byte. It then holds done high with pass low and accepts no further start until reset. A run that passes may be started again.

Top module: `bus_selftest`

## Requirements
- R1: After reset, done_o, pass_o, req_o and all four fail fields are 0.
- R2: The data-line phase writes 1<<k to address 0 for k = 0 up to 7, in rising order. Each write is followed by a read of address 0. A mismatch ends the run with fail phase code 1 (data lines).
- R3: The address-line phase touches only address 0 and the offsets 2^i for i < ADDR_W. A passing fast run makes 8+(ADDR_W+1)+2+2·ADDR_W writes and 8+ADDR_W+ADDR_W² reads. For ADDR_W=6 that is 29 writes and 50 reads.
- R4: After 0x55 is written to offset 0, every power-of-two offset must still read 0xAA. An address line stuck low or stuck high is reported with fail phase code 2 (address lines), expected 0xAA, got 0x55, at the first offset that aliases.
- R5: The engine writes 0x55 to each power-of-two offset in turn, then restores it to 0xAA. While an offset holds 0x55, offset 0 and every other power-of-two offset are checked for 0xAA, in rising address order. Two shorted address lines are reported with fail phase code 2 at the first offset that reads 0x55.
- R6: Full mode adds a sweep. It writes 0xAA to every address in rising order, then verifies every address. It then does the same with 0x55. This adds 2·2^ADDR_W writes and 2·2^ADDR_W reads. A mismatch in the sweep is reported with fail phase code 3 (sweep).
- R7: Fast mode (full_i low at start) performs no sweep. A fault in a cell outside address 0 and the power-of-two offsets still gives pass.
- R8: On the first mismatch the engine stops issuing accesses. It latches the phase code, address, expected byte and read byte, and then holds done_o high and pass_o low.
- R9: After a failure, start_i has no effect until reset. No access is issued and the fail fields hold their values.
- R10: At most one read is outstanding. Read data is compared only in a cycle where rvalid_i is high, whatever the response latency.
- R11: A start pulse during a run is ignored. After a passing run, a new start pulse starts a complete new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a run when idle or after a pass |
| full_i | input | 1 | Sampled at start: 1 adds the sweep phase |
| req_o | output | 1 | Access request, one access per high cycle |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | ADDR_W | Byte address of the access |
| wdata_o | output | 8 | Write byte |
| rdata_i | input | 8 | Read byte, valid with rvalid_i |
| rvalid_i | input | 1 | Read response strobe |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_phase_o | output | 2 | 0 none, 1 data lines, 2 address lines, 3 sweep |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | 8 | Expected byte at the first mismatch |
| fail_got_o | output | 8 | Byte read at the first mismatch |

## Verification
A read response and a start pulse can arrive in the same cycle. The engine must then finish the compare, ignore the start and leave the access sequence unchanged. The bench provokes this by waiting for a response strobe inside a run and raising start in that same cycle. It then judges the case by the run's write and read totals, which must match the arithmetic counts exactly. Injected faults (a stuck data bit, an address bit stuck low or high, two shorted address bits, a single bad cell) are checked against fail fields worked out by hand from the access order. The response latency changes from read to read, so every compare depends on the response strobe and not on a fixed delay.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DB_W,
        ST_DB_R,
        ST_AF,
        ST_LW,
        ST_LR,
        ST_LF,
        ST_HW,
        ST_HR,
        ST_HF,
        ST_FW,
        ST_FR,
        ST_DONE
    } st_e;

    localparam logic [7:0] PAT_A = 8'hAA;
    localparam logic [7:0] PAT_B = 8'h55;

    localparam logic [1:0] PH_NONE = 2'd0;
    localparam logic [1:0] PH_DATA = 2'd1;
    localparam logic [1:0] PH_ADDR = 2'd2;
    localparam logic [1:0] PH_FULL = 2'd3;

    function automatic logic [1:0] phase_of(input st_e s);
        case (s)
            ST_DB_W, ST_DB_R:                    phase_of = PH_DATA;
            ST_AF, ST_LW, ST_LR, ST_LF,
            ST_HW, ST_HR, ST_HF:                 phase_of = PH_ADDR;
            ST_FW, ST_FR:                        phase_of = PH_FULL;
            default:                             phase_of = PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bst_loc_map.sv
// Maps a location index to a byte offset: 0 -> 0, i -> 1 << (i-1).
module bst_loc_map #(
    parameter int AW = 23,
    parameter int IW = $clog2(AW + 1)
) (
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] loc_o
);
    for (genvar k = 0; k < AW; k++) begin : g_bit
        assign loc_o[k] = (idx_i == IW'(k + 1));
    end
endmodule

// File: rtl/bst_result.sv
module bst_result #(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_evt_i,
    input  logic [1:0]    phase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    exp_i,
    input  logic [7:0]    got_i,
    output logic          locked_o,
    output logic [1:0]    phase_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    exp_o,
    output logic [7:0]    got_o
);
    typedef struct packed {
        logic          locked;
        logic [1:0]    phase;
        logic [AW-1:0] addr;
        logic [7:0]    exp;
        logic [7:0]    got;
    } res_t;

    res_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (fail_evt_i && !r_q.locked) begin
            r_d.locked = 1'b1;
            r_d.phase  = phase_i;
            r_d.addr   = addr_i;
            r_d.exp    = exp_i;
            r_d.got    = got_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign locked_o = r_q.locked;
    assign phase_o  = r_q.phase;
    assign addr_o   = r_q.addr;
    assign exp_o    = r_q.exp;
    assign got_o    = r_q.got;

    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.locked |=> (r_q.locked && $stable(r_q.addr) && $stable(r_q.got)
                        && $stable(r_q.exp) && $stable(r_q.phase)));

    assert_phase_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt_i |-> (phase_i != 2'd0));
endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
    import bst_pkg::*;
#(
    parameter int AW = 23,
    parameter int IW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          full_i,
    input  logic          locked_i,
    input  logic [7:0]    rdata_i,
    input  logic          rvalid_i,
    input  logic [AW-1:0] loc_idx_i,
    input  logic [AW-1:0] loc_j_i,
    output logic [IW-1:0] idx_o,
    output logic [IW-1:0] j_o,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    wdata_o,
    output logic [7:0]    exp_o,
    output logic [1:0]    phase_o,
    output logic          fail_evt_o,
    output logic          done_o
);
    localparam logic [IW-1:0] LAST = IW'(AW);
    localparam logic [IW-1:0] ONE  = IW'(1);

    typedef struct packed {
        st_e           st;
        logic [IW-1:0] idx;
        logic [IW-1:0] j;
        logic [AW-1:0] cnt;
        logic          pat;
        logic          full;
        logic          pend;
    } cs_t;

    cs_t c_q, c_d;

    logic          rd_st, issue, got, bad, ok;
    logic [IW-1:0] nx, hr_last;
    logic [7:0]    bit_val;

    always_comb begin
        c_d        = c_q;
        req_o      = 1'b0;
        we_o       = 1'b0;
        addr_o     = '0;
        wdata_o    = '0;
        exp_o      = '0;
        fail_evt_o = 1'b0;
        bit_val    = 8'(1) << c_q.cnt[2:0];
        nx         = c_q.idx + ONE;
        if (nx == c_q.j) nx = nx + ONE;
        hr_last    = (c_q.j == LAST) ? (LAST - ONE) : LAST;

        // access attributes per state
        case (c_q.st)
            ST_DB_W: begin we_o = 1'b1; wdata_o = bit_val; end
            ST_DB_R: exp_o = bit_val;
            ST_AF:   begin we_o = 1'b1; addr_o = loc_idx_i; wdata_o = PAT_A; end
            ST_LW:   begin we_o = 1'b1; wdata_o = PAT_B; end
            ST_LR:   begin addr_o = loc_idx_i; exp_o = PAT_A; end
            ST_LF:   begin we_o = 1'b1; wdata_o = PAT_A; end
            ST_HW:   begin we_o = 1'b1; addr_o = loc_j_i; wdata_o = PAT_B; end
            ST_HR:   begin addr_o = loc_idx_i; exp_o = PAT_A; end
            ST_HF:   begin we_o = 1'b1; addr_o = loc_j_i; wdata_o = PAT_A; end
            ST_FW:   begin we_o = 1'b1; addr_o = c_q.cnt; wdata_o = c_q.pat ? PAT_B : PAT_A; end
            ST_FR:   begin addr_o = c_q.cnt; exp_o = c_q.pat ? PAT_B : PAT_A; end
            default: ;
        endcase

        rd_st = (c_q.st == ST_DB_R) || (c_q.st == ST_LR) ||
                (c_q.st == ST_HR)   || (c_q.st == ST_FR);
        issue = rd_st && !c_q.pend;
        got   = rd_st && c_q.pend && rvalid_i;
        bad   = got && (rdata_i != exp_o);
        ok    = got && !bad;

        if (we_o) req_o = 1'b1;
        if (issue) begin
            req_o    = 1'b1;
            c_d.pend = 1'b1;
        end
        if (got) c_d.pend = 1'b0;
        if (bad) begin
            fail_evt_o = 1'b1;
            c_d.st     = ST_DONE;
        end

        case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i && !locked_i) begin
                    c_d.st   = ST_DB_W;
                    c_d.cnt  = '0;
                    c_d.idx  = '0;
                    c_d.j    = '0;
                    c_d.pat  = 1'b0;
                    c_d.full = full_i;
                    c_d.pend = 1'b0;
                end
            end
            ST_DB_W: c_d.st = ST_DB_R;
            ST_DB_R: if (ok) begin
                if (c_q.cnt[2:0] == 3'd7) begin
                    c_d.st  = ST_AF;
                    c_d.idx = '0;
                    c_d.cnt = '0;
                end else begin
                    c_d.st  = ST_DB_W;
                    c_d.cnt = c_q.cnt + AW'(1);
                end
            end
            ST_AF: begin
                if (c_q.idx == LAST) c_d.st = ST_LW;
                else                 c_d.idx = c_q.idx + ONE;
            end
            ST_LW: begin
                c_d.st  = ST_LR;
                c_d.idx = ONE;
            end
            ST_LR: if (ok) begin
                if (c_q.idx == LAST) c_d.st = ST_LF;
                else                 c_d.idx = c_q.idx + ONE;
            end
            ST_LF: begin
                c_d.st = ST_HW;
                c_d.j  = ONE;
            end
            ST_HW: begin
                c_d.st  = ST_HR;
                c_d.idx = '0;
            end
            ST_HR: if (ok) begin
                if (c_q.idx == hr_last) c_d.st = ST_HF;
                else                    c_d.idx = nx;
            end
            ST_HF: begin
                if (c_q.j == LAST) begin
                    c_d.st  = c_q.full ? ST_FW : ST_DONE;
                    c_d.cnt = '0;
                    c_d.pat = 1'b0;
                end else begin
                    c_d.st = ST_HW;
                    c_d.j  = c_q.j + ONE;
                end
            end
            ST_FW: begin
                if (&c_q.cnt) begin
                    c_d.st  = ST_FR;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + AW'(1);
                end
            end
            ST_FR: if (ok) begin
                if (&c_q.cnt) begin
                    c_d.cnt = '0;
                    if (!c_q.pat) begin
                        c_d.pat = 1'b1;
                        c_d.st  = ST_FW;
                    end else begin
                        c_d.st  = ST_DONE;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + AW'(1);
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign idx_o   = c_q.idx;
    assign j_o     = c_q.j;
    assign phase_o = phase_of(c_q.st);
    assign done_o  = (c_q.st == ST_DONE);

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !we_o) |=> !req_o);

    assert_wait_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.pend && !rvalid_i) |=> c_q.pend);

    assert_walking_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && phase_o == PH_DATA) |-> (addr_o == '0 && (!we_o || $countones(wdata_o) == 1)));

    assert_addr_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && phase_o == PH_ADDR) |-> ($countones(addr_o) <= 1));

    assert_fail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt_o |=> (done_o && !req_o));

    assert_sweep_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_FULL) |-> c_q.full);
endmodule

// File: rtl/bus_selftest.sv
module bus_selftest #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              full_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        wdata_o,
    input  logic [7:0]        rdata_i,
    input  logic              rvalid_i,
    output logic              done_o,
    output logic              pass_o,
    output logic [1:0]        fail_phase_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [7:0]        fail_exp_o,
    output logic [7:0]        fail_got_o
);
    localparam int IW = $clog2(ADDR_W + 1);

    logic [IW-1:0]     idx, jdx;
    logic [ADDR_W-1:0] loc_idx, loc_j;
    logic [7:0]        exp_b;
    logic [1:0]        phase;
    logic              fail_evt, locked, done;

    bst_loc_map #(.AW(ADDR_W), .IW(IW)) u_map_idx (.idx_i(idx), .loc_o(loc_idx));
    bst_loc_map #(.AW(ADDR_W), .IW(IW)) u_map_j   (.idx_i(jdx), .loc_o(loc_j));

    bst_ctrl #(.AW(ADDR_W), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .full_i     (full_i),
        .locked_i   (locked),
        .rdata_i    (rdata_i),
        .rvalid_i   (rvalid_i),
        .loc_idx_i  (loc_idx),
        .loc_j_i    (loc_j),
        .idx_o      (idx),
        .j_o        (jdx),
        .req_o      (req_o),
        .we_o       (we_o),
        .addr_o     (addr_o),
        .wdata_o    (wdata_o),
        .exp_o      (exp_b),
        .phase_o    (phase),
        .fail_evt_o (fail_evt),
        .done_o     (done)
    );

    bst_result #(.AW(ADDR_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_evt_i (fail_evt),
        .phase_i    (phase),
        .addr_i     (addr_o),
        .exp_i      (exp_b),
        .got_i      (rdata_i),
        .locked_o   (locked),
        .phase_o    (fail_phase_o),
        .addr_o     (fail_addr_o),
        .exp_o      (fail_exp_o),
        .got_o      (fail_got_o)
    );

    assign done_o = done;
    assign pass_o = done && !locked;

    assert_locked_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && done_o) |=> (done_o && !pass_o && !req_o));
endmodule

// File: tb/bus_selftest_tb_top.sv
module bus_selftest_tb_top;
    localparam int AW = 6;
    localparam int SZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          full = 1'b0;
    logic          req, we;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata = 8'h00;
    logic          rvalid = 1'b0;
    logic          done, pass;
    logic [1:0]    fphase;
    logic [AW-1:0] faddr;
    logic [7:0]    fexp, fgot;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // fault modes: 0 none, 1 addr bit2 stuck low, 2 addr bit4 stuck high,
    // 3 addr bits 1 and 3 shorted, 4 read data bit3 stuck low, 5 cell 45 bit0 stuck low
    int fault = 0;
    int nw = 0, nr = 0, viol = 0, rdn = 0;
    int lat = 0;
    logic [7:0] rbuf = 8'h00;
    logic [7:0] mem [SZ];

    always #4 clk = ~clk;

    bus_selftest #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .full_i(full),
        .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
        .rdata_i(rdata), .rvalid_i(rvalid),
        .done_o(done), .pass_o(pass), .fail_phase_o(fphase),
        .fail_addr_o(faddr), .fail_exp_o(fexp), .fail_got_o(fgot)
    );

    function automatic int phys(input int a);
        int p = a;
        case (fault)
            1: p = a & ~4;
            2: p = a | 16;
            3: if (((a >> 1) & 1) != 0 || ((a >> 3) & 1) != 0) p = a | 10;
            default: ;
        endcase
        return p;
    endfunction

    always @(posedge clk) begin
        rvalid <= 1'b0;
        if (rst_n) begin
            if (req && lat != 0) viol++;
            if (req && we) begin
                nw++;
                if (fault == 5 && phys(int'(addr)) == 45) mem[45] <= wdata & 8'hFE;
                else mem[phys(int'(addr))] <= wdata;
            end else if (req) begin
                nr++;
                lat  <= 1 + (rdn % 3);
                rdn++;
                rbuf <= (fault == 4) ? (mem[phys(int'(addr))] & 8'hF7) : mem[phys(int'(addr))];
            end else if (lat != 0) begin
                lat <= lat - 1;
                if (lat == 1) begin
                    rvalid <= 1'b1;
                    rdata  <= rbuf;
                end
            end
        end
    end

    task automatic check(input string r, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", r, got, exp);
        end
    endtask

    task automatic do_reset(input int f);
        @(negedge clk);
        rst_n = 1'b0;
        fault = f;
        lat   = 0;
        for (int i = 0; i < SZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start(input logic f);
        full = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic f, input logic poke);
        int t = 0;
        @(negedge clk);
        nw = 0; nr = 0; viol = 0;
        pulse_start(f);
        if (poke) begin
            while (!rvalid && t < 2000) begin @(negedge clk); t++; end
            start = 1'b1;   // coincides with a read response
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        if (!done) begin
            n_bad++;
            $display("FAIL R8 run did not finish actual=0 expected=1");
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    localparam int FW = 8 + (AW + 1) + 2 + 2 * AW;
    localparam int FR = 8 + AW + AW * AW;

    initial begin
        // R1 reset state
        do_reset(0);
        @(negedge clk);
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 req",  int'(req), 0);
        check("R1 fail fields", int'({fphase, faddr, fexp, fgot}), 0);

        // R3, R10, R11: fast run, with a start pulse landing on a read response
        run(1'b0, 1'b1);
        check("R3 fast pass", int'(pass), 1);
        check("R3 fast writes", nw, FW);
        check("R11 fast reads (start ignored)", nr, FR);
        check("R10 outstanding", viol, 0);

        // R11 restart after a pass
        run(1'b0, 1'b0);
        check("R11 restart pass", int'(pass), 1);
        check("R11 restart writes", nw, FW);
        check("R11 restart reads", nr, FR);

        // R6 full run passes
        do_reset(0);
        run(1'b1, 1'b0);
        check("R6 full pass", int'(pass), 1);
        check("R6 full writes", nw, FW + 2 * SZ);
        check("R6 full reads", nr, FR + 2 * SZ);
        check("R10 outstanding full", viol, 0);

        // R2 data bit 3 stuck low
        do_reset(4);
        run(1'b0, 1'b0);
        check("R2 pass low", int'(pass), 0);
        check("R2 phase", int'(fphase), 1);
        check("R2 addr", int'(faddr), 0);
        check("R2 exp", int'(fexp), 8'h08);
        check("R2 got", int'(fgot), 8'h00);
        check("R8 stopped after 4 data writes", nw, 4);

        // R4 address bit 2 stuck low
        do_reset(1);
        run(1'b0, 1'b0);
        check("R4 low phase", int'(fphase), 2);
        check("R4 low addr", int'(faddr), 4);
        check("R4 low exp", int'(fexp), 8'hAA);
        check("R4 low got", int'(fgot), 8'h55);

        // R4 address bit 4 stuck high
        do_reset(2);
        run(1'b0, 1'b0);
        check("R4 high phase", int'(fphase), 2);
        check("R4 high addr", int'(faddr), 16);
        check("R4 high got", int'(fgot), 8'h55);

        // R5 address bits 1 and 3 shorted
        do_reset(3);
        run(1'b0, 1'b0);
        check("R5 short phase", int'(fphase), 2);
        check("R5 short addr", int'(faddr), 8);
        check("R5 short exp", int'(fexp), 8'hAA);
        check("R5 short got", int'(fgot), 8'h55);

        // R7 fast run misses a bad cell
        do_reset(5);
        run(1'b0, 1'b0);
        check("R7 fast pass with bad cell", int'(pass), 1);

        // R6, R8 full run finds it
        do_reset(5);
        run(1'b1, 1'b0);
        check("R8 done", int'(done), 1);
        check("R8 pass low", int'(pass), 0);
        check("R6 sweep phase", int'(fphase), 3);
        check("R6 sweep addr", int'(faddr), 45);
        check("R6 sweep exp", int'(fexp), 8'h55);
        check("R6 sweep got", int'(fgot), 8'h54);

        // R9 start ignored after failure
        nw = 0; nr = 0;
        pulse_start(1'b1);
        repeat (40) @(negedge clk);
        check("R9 no access", nw + nr, 0);
        check("R9 done held", int'(done), 1);
        check("R9 addr held", int'(faddr), 45);
        check("R9 phase held", int'(fphase), 3);

        do_reset(0);
        @(negedge clk);
        check("R1 cleared by reset", int'({done, fphase, faddr}), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule